// File: doc/BRIEF.md
# Tape Frame to Word Packer

This block sits between a tape data path that moves 8-bit frames and a memory side that moves 16-bit words. On a read it takes the frames of one record and packs them into words. On a write it takes words and splits them into frames. Both directions use valid/ready streams. A start pulse fixes the operation, the packing mode and the requested word count for the whole transfer. When the transfer ends, the block updates a frame-count register, a short-record error flag and a tape-mark flag, and raises a one-cycle done pulse.

Two packing modes are offered. Byte mode carries one full frame per lane, so each word holds two frames. Nibble mode (the core-dump layout) carries only the low four bits of each frame, so each word holds four frames. A reverse read delivers the record last frame first. The block packs frames strictly in arrival order, so the last frame of the record lands in the lowest lane of the first word. The last word of a record is padded with zeros when the record ends part-way through it. A tape-mark beat in place of data ends a read at once.

Top module: `tape_frame_packer`

## Requirements
- R1: After reset, busy_o, done_o, fcnt_o, fcnt_err_o, mark_o, word_valid_o, tx_valid_o, frm_ready_o and wr_ready_o are all zero.
- R2: In a byte-mode read (nib_i=0 at start), the frames of each word are placed in arrival order: the first frame goes to bits 7:0 and the second to bits 15:8.
- R3: In a nibble-mode read (nib_i=1 at start), bits 3:0 of four consecutive frames fill word bits 3:0, 7:4, 11:8 and 15:12 in arrival order. Frame bits 7:4 are ignored.
- R4: In a reverse read, frames arrive last frame first. The last frame of the record is placed in bits 7:0 (byte mode) or bits 3:0 (nibble mode) of the first word.
- R5: When a record ends before a word is full, the unfilled lanes of the final word are zero, and that word is still delivered.
- R6: When a read ends, fcnt_o equals the number of data frames mod 65536. fcnt_err_o is 1 exactly when the requested count is greater than the number of words delivered.
- R7: A frame beat with frm_mark_i=1 ends a read with no word delivered. It sets fcnt_err_o=1, mark_o=1 and fcnt_o=0.
- R8: In a byte-mode write (op_i=1), each word is sent as two frames, bits 7:0 first. tx_last_o is 1 only on the final frame of the final word.
- R9: In a nibble-mode write, each word is sent as four frames, lowest nibble first. Each frame carries its nibble in bits 3:0, with bits 7:4 zero.
- R10: When a write ends, fcnt_o equals its previous value plus the number of frames sent, mod 65536. fcnt_err_o and mark_o are 0. A write of zero words sends no frame and leaves fcnt_o unchanged.
- R11: op_i, nib_i and req_cnt_i are sampled only by a start_i pulse while busy_o is 0. A start_i pulse while busy_o is 1 has no effect on the transfer in progress.
- R12: A word or frame offered with its ready low is held, unchanged, until it is accepted. Backpressure loses no data and reorders nothing.
- R13: done_o is a one-cycle pulse in the cycle after the last transfer handshake. fcnt_o, fcnt_err_o and mark_o change only in that cycle and hold their value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse; samples op_i, nib_i, req_cnt_i when idle |
| op_i | input | 1 | 0 = read (frames to words), 1 = write (words to frames) |
| nib_i | input | 1 | 0 = byte mode, 1 = nibble mode |
| req_cnt_i | input | 16 | Read: requested word count; write: words to send |
| frm_valid_i | input | 1 | Incoming frame valid |
| frm_data_i | input | 8 | Incoming frame |
| frm_last_i | input | 1 | Incoming frame is the last of the record |
| frm_mark_i | input | 1 | Beat is a tape mark, not data |
| frm_ready_o | output | 1 | Block accepts an incoming frame |
| word_valid_o | output | 1 | Packed word valid |
| word_data_o | output | 16 | Packed word |
| word_ready_i | input | 1 | Memory side accepts the word |
| wr_valid_i | input | 1 | Word to write valid |
| wr_data_i | input | 16 | Word to write |
| wr_ready_o | output | 1 | Block accepts a word to write |
| tx_valid_o | output | 1 | Outgoing frame valid |
| tx_data_o | output | 8 | Outgoing frame |
| tx_last_o | output | 1 | Outgoing frame is the last of the transfer |
| tx_ready_i | input | 1 | Tape side accepts the frame |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fcnt_o | output | 16 | Frame count register |
| fcnt_err_o | output | 1 | Frame-count (short record or tape mark) error |
| mark_o | output | 1 | Last read ended on a tape mark |

## Verification
A lane pointer that slips, or a packing register that is not cleared, shows up on the very next delivered word. That word carries a frame in the wrong bit field, or stale bits where zero padding belongs. The bench compares every word and frame handshake against its own queue-based model, so such a fault is reported within one word time. A wrong frame or word counter stays hidden until the done pulse, where fcnt_o or fcnt_err_o disagrees. Because fcnt_o accumulates across writes, a counting fault also spoils every later completion. A start that is wrongly taken while busy changes the packing of the words that follow, or emits frames on the tape side, within a cycle or two.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } tfp_op_e;

   typedef enum logic {
      LANE_BYTE   = 1'b0,
      LANE_NIBBLE = 1'b1
   } tfp_lane_e;
endpackage

// File: rtl/tfp_pack.sv
module tfp_pack #(
   parameter int WORD_W  = 16,
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm_i,
   input  logic               nib_i,
   input  logic               frm_valid_i,
   input  logic [FRAME_W-1:0] frm_data_i,
   input  logic               frm_last_i,
   input  logic               frm_mark_i,
   output logic               frm_ready_o,
   output logic               word_valid_o,
   output logic [WORD_W-1:0]  word_data_o,
   input  logic               word_ready_i,
   output logic               data_take_o,
   output logic               mark_take_o,
   output logic               word_made_o,
   output logic               rec_end_o
);
   localparam int HALF_W     = FRAME_W / 2;
   localparam int BYTE_LANES = WORD_W / FRAME_W;
   localparam int NIB_LANES  = WORD_W / HALF_W;
   localparam int LANE_W     = (NIB_LANES > 1) ? $clog2(NIB_LANES) : 1;
   localparam int SH_W       = $clog2(WORD_W) + 1;

   generate
      if (FRAME_W < 2 || (FRAME_W % 2) != 0) begin : g_bad_frame
         $error("tfp_pack: FRAME_W must be even and at least 2");
      end
      if ((WORD_W % FRAME_W) != 0 || WORD_W < 2 * FRAME_W) begin : g_bad_word
         $error("tfp_pack: WORD_W must be a multiple of FRAME_W, at least two frames");
      end
   endgenerate

   logic              active_q, ending_q, wv_q;
   logic [WORD_W-1:0] acc_q, wd_q;
   logic [LANE_W-1:0] lane_q;

   logic              drain_ok, take, data_take, closes, word_made, rec_end;
   logic [WORD_W-1:0] field, merged;
   logic [SH_W-1:0]   shamt;
   logic [LANE_W-1:0] lane_top;

   assign drain_ok    = !wv_q || word_ready_i;
   assign frm_ready_o = active_q && !ending_q && drain_ok;
   assign take        = frm_valid_i && frm_ready_o;
   assign data_take   = take && !frm_mark_i;

   always_comb begin
      if (nib_i == tfp_pkg::LANE_NIBBLE) begin
         field    = WORD_W'(frm_data_i[HALF_W-1:0]);
         shamt    = SH_W'(32'(lane_q) * HALF_W);
         lane_top = LANE_W'(NIB_LANES - 1);
      end else begin
         field    = WORD_W'(frm_data_i);
         shamt    = SH_W'(32'(lane_q) * FRAME_W);
         lane_top = LANE_W'(BYTE_LANES - 1);
      end
      merged = acc_q | (field << shamt);
   end

   assign closes    = (lane_q == lane_top) || frm_last_i;
   assign word_made = data_take && closes;
   assign rec_end   = active_q && ending_q && drain_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ending_q <= 1'b0;
         wv_q     <= 1'b0;
         acc_q    <= '0;
         wd_q     <= '0;
         lane_q   <= '0;
      end else begin
         if (word_made) begin
            acc_q  <= '0;
            lane_q <= '0;
         end else if (data_take) begin
            acc_q  <= merged;
            lane_q <= lane_q + 1'b1;
         end
         if (word_made) begin
            wv_q <= 1'b1;
            wd_q <= merged;
         end else if (word_ready_i) begin
            wv_q <= 1'b0;
         end
         if (arm_i) begin
            active_q <= 1'b1;
            ending_q <= 1'b0;
            acc_q    <= '0;
            lane_q   <= '0;
         end else if (rec_end) begin
            active_q <= 1'b0;
            ending_q <= 1'b0;
         end else if (take && (frm_last_i || frm_mark_i)) begin
            ending_q <= 1'b1;
         end
      end
   end

   assign word_valid_o = wv_q;
   assign word_data_o  = wd_q;
   assign data_take_o  = data_take;
   assign mark_take_o  = take && frm_mark_i;
   assign word_made_o  = word_made;
   assign rec_end_o    = rec_end;

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wv_q && !word_ready_i) |=> (wv_q && $stable(wd_q))); // R12

   AST_NO_TAKE_WHEN_ENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (ending_q && frm_valid_i) |-> !take); // R7
endmodule

// File: rtl/tfp_split.sv
module tfp_split #(
   parameter int WORD_W  = 16,
   parameter int FRAME_W = 8,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm_i,
   input  logic [CNT_W-1:0]   req_i,
   input  logic               nib_i,
   input  logic               wr_valid_i,
   input  logic [WORD_W-1:0]  wr_data_i,
   output logic               wr_ready_o,
   output logic               tx_valid_o,
   output logic [FRAME_W-1:0] tx_data_o,
   output logic               tx_last_o,
   input  logic               tx_ready_i,
   output logic               frame_sent_o,
   output logic               xfer_end_o
);
   localparam int HALF_W     = FRAME_W / 2;
   localparam int BYTE_LANES = WORD_W / FRAME_W;
   localparam int NIB_LANES  = WORD_W / HALF_W;
   localparam int REM_W      = $clog2(NIB_LANES + 1);

   logic              active_q;
   logic [WORD_W-1:0] sh_q;
   logic [REM_W-1:0]  rem_q;
   logic [CNT_W-1:0]  left_q;

   logic accept, sent;

   assign wr_ready_o = active_q && (rem_q == '0) && (left_q != '0);
   assign accept     = wr_valid_i && wr_ready_o;
   assign tx_valid_o = rem_q != '0;
   assign sent       = tx_valid_o && tx_ready_i;
   assign tx_last_o  = tx_valid_o && (rem_q == REM_W'(1)) && (left_q == '0);
   assign xfer_end_o = active_q && (left_q == '0) && (rem_q == '0);
   assign frame_sent_o = sent;

   always_comb begin
      if (nib_i == tfp_pkg::LANE_NIBBLE) tx_data_o = FRAME_W'(sh_q[HALF_W-1:0]);
      else                               tx_data_o = sh_q[FRAME_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sh_q     <= '0;
         rem_q    <= '0;
         left_q   <= '0;
      end else begin
         if (accept) begin
            sh_q   <= wr_data_i;
            rem_q  <= (nib_i == tfp_pkg::LANE_NIBBLE) ? REM_W'(NIB_LANES) : REM_W'(BYTE_LANES);
            left_q <= left_q - 1'b1;
         end else if (sent) begin
            sh_q  <= (nib_i == tfp_pkg::LANE_NIBBLE) ? (sh_q >> HALF_W) : (sh_q >> FRAME_W);
            rem_q <= rem_q - 1'b1;
         end
         if (arm_i) begin
            active_q <= 1'b1;
            left_q   <= req_i;
            rem_q    <= '0;
         end else if (xfer_end_o) begin
            active_q <= 1'b0;
         end
      end
   end

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R12

   AST_NIB_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_i && tx_valid_o) |-> (tx_data_o[FRAME_W-1:HALF_W] == '0)); // R9

   AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && tx_ready_i && tx_last_o) |=> !tx_valid_o); // R8
endmodule

// File: rtl/tape_frame_packer.sv
module tape_frame_packer #(
   parameter int WORD_W  = 16,
   parameter int FRAME_W = 8,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               op_i,
   input  logic               nib_i,
   input  logic [CNT_W-1:0]   req_cnt_i,
   input  logic               frm_valid_i,
   input  logic [FRAME_W-1:0] frm_data_i,
   input  logic               frm_last_i,
   input  logic               frm_mark_i,
   output logic               frm_ready_o,
   output logic               word_valid_o,
   output logic [WORD_W-1:0]  word_data_o,
   input  logic               word_ready_i,
   input  logic               wr_valid_i,
   input  logic [WORD_W-1:0]  wr_data_i,
   output logic               wr_ready_o,
   output logic               tx_valid_o,
   output logic [FRAME_W-1:0] tx_data_o,
   output logic               tx_last_o,
   input  logic               tx_ready_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [CNT_W-1:0]   fcnt_o,
   output logic               fcnt_err_o,
   output logic               mark_o
);
   import tfp_pkg::*;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("tape_frame_packer: CNT_W must be at least 2");
      end
   endgenerate

   logic             busy_q, nib_q, mark_seen_q, done_q, err_q, mark_q;
   tfp_op_e          op_q;
   logic [CNT_W-1:0] req_q, fr_cnt_q, wd_cnt_q, fcnt_q;

   logic launch, arm_rd, arm_wr, finish;
   logic rd_data_take, rd_mark_take, rd_word_made, rd_end;
   logic wr_frame_sent, wr_end;

   assign launch = start_i && !busy_q;
   assign arm_rd = launch && (tfp_op_e'(op_i) == OP_READ);
   assign arm_wr = launch && (tfp_op_e'(op_i) == OP_WRITE);

   tfp_pack #(.WORD_W(WORD_W), .FRAME_W(FRAME_W)) u_pack (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_i        (arm_rd),
      .nib_i        (nib_q),
      .frm_valid_i  (frm_valid_i),
      .frm_data_i   (frm_data_i),
      .frm_last_i   (frm_last_i),
      .frm_mark_i   (frm_mark_i),
      .frm_ready_o  (frm_ready_o),
      .word_valid_o (word_valid_o),
      .word_data_o  (word_data_o),
      .word_ready_i (word_ready_i),
      .data_take_o  (rd_data_take),
      .mark_take_o  (rd_mark_take),
      .word_made_o  (rd_word_made),
      .rec_end_o    (rd_end)
   );

   tfp_split #(.WORD_W(WORD_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_split (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_i        (arm_wr),
      .req_i        (req_cnt_i),
      .nib_i        (nib_q),
      .wr_valid_i   (wr_valid_i),
      .wr_data_i    (wr_data_i),
      .wr_ready_o   (wr_ready_o),
      .tx_valid_o   (tx_valid_o),
      .tx_data_o    (tx_data_o),
      .tx_last_o    (tx_last_o),
      .tx_ready_i   (tx_ready_i),
      .frame_sent_o (wr_frame_sent),
      .xfer_end_o   (wr_end)
   );

   assign finish = busy_q && ((op_q == OP_WRITE) ? wr_end : rd_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         op_q        <= OP_READ;
         nib_q       <= 1'b0;
         req_q       <= '0;
         fr_cnt_q    <= '0;
         wd_cnt_q    <= '0;
         mark_seen_q <= 1'b0;
         fcnt_q      <= '0;
         err_q       <= 1'b0;
         mark_q      <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         done_q <= finish;
         if (launch) begin
            busy_q      <= 1'b1;
            op_q        <= tfp_op_e'(op_i);
            nib_q       <= nib_i;
            req_q       <= req_cnt_i;
            fr_cnt_q    <= '0;
            wd_cnt_q    <= '0;
            mark_seen_q <= 1'b0;
         end else begin
            if (rd_data_take || wr_frame_sent) fr_cnt_q <= fr_cnt_q + 1'b1;
            if (rd_word_made)                  wd_cnt_q <= wd_cnt_q + 1'b1;
            if (rd_mark_take)                  mark_seen_q <= 1'b1;
            if (finish) begin
               busy_q <= 1'b0;
               if (op_q == OP_WRITE) begin
                  fcnt_q <= fcnt_q + fr_cnt_q;
                  err_q  <= 1'b0;
                  mark_q <= 1'b0;
               end else begin
                  fcnt_q <= fr_cnt_q;
                  err_q  <= mark_seen_q || (req_q > wd_cnt_q);
                  mark_q <= mark_seen_q;
               end
            end
         end
      end
   end

   assign busy_o     = busy_q;
   assign done_o     = done_q;
   assign fcnt_o     = fcnt_q;
   assign fcnt_err_o = err_q;
   assign mark_o     = mark_q;

   AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(frm_ready_o && wr_ready_o)); // R11

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i) |=> ($stable(req_q) && $stable(op_q) && $stable(nib_q))); // R11

   AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fcnt_err_o) |-> done_o); // R6

   AST_FCNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(fcnt_o) && $stable(mark_o))); // R13

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R13
endmodule

// File: tb/tape_frame_packer_test.sv
module tape_frame_packer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, op_i = 1'b0, nib_i = 1'b0;
   logic [15:0] req_cnt_i = '0;
   logic        frm_valid_i = 1'b0, frm_last_i = 1'b0, frm_mark_i = 1'b0;
   logic [7:0]  frm_data_i = '0;
   logic        frm_ready_o, word_valid_o;
   logic [15:0] word_data_o;
   logic        word_ready_i = 1'b1;
   logic        wr_valid_i = 1'b0;
   logic [15:0] wr_data_i = '0;
   logic        wr_ready_o, tx_valid_o, tx_last_o;
   logic [7:0]  tx_data_o;
   logic        tx_ready_i = 1'b1;
   logic        busy_o, done_o, fcnt_err_o, mark_o;
   logic [15:0] fcnt_o;

   always #10 clk = ~clk;

   tape_frame_packer uut (.*);

   int checks = 0, errors = 0;
   bit finished = 0, mon_on = 0, prev_done = 0;
   bit stall_w = 0, stall_t = 0;
   string cur_tag = "R1";
   bit cur_op = 0;
   int exp_fcnt = 0;
   bit exp_err = 0, exp_mark = 0;
   logic [15:0] exp_w[$];
   logic [8:0]  exp_f[$];
   logic [15:0] lf = 16'hACE1;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // ready patterns for the backpressure cases (R12)
   always begin
      @(posedge clk);
      #2;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      word_ready_i = !stall_w || lf[0] || lf[3];
      tx_ready_i   = !stall_t || lf[1] || lf[5];
   end

   // handshake-by-handshake comparison against the bench model
   always @(negedge clk) begin
      if (mon_on) begin
         if (word_valid_o && word_ready_i) begin
            if (exp_w.size() == 0) chk(0, {cur_tag, " unexpected word"}, word_data_o, 0);
            else begin
               logic [15:0] e;
               e = exp_w.pop_front();
               chk(word_data_o == e, {cur_tag, " word"}, word_data_o, e);
            end
         end
         if (tx_valid_o && tx_ready_i) begin
            if (exp_f.size() == 0) chk(0, {cur_tag, " unexpected frame"}, tx_data_o, 0);
            else begin
               logic [8:0] e;
               e = exp_f.pop_front();
               chk({tx_last_o, tx_data_o} == e, {cur_tag, " frame"}, {tx_last_o, tx_data_o}, e);
            end
         end
         if (done_o) begin
            chk(fcnt_o == exp_fcnt[15:0], cur_op ? "R10 fcnt" : "R6 fcnt", fcnt_o, exp_fcnt[15:0]);
            chk(fcnt_err_o == exp_err, exp_mark ? "R7 err" : (cur_op ? "R10 err" : "R6 err"),
                fcnt_err_o, exp_err);
            chk(mark_o == exp_mark, "R7 mark", mark_o, exp_mark);
            chk(exp_w.size() == 0 && exp_f.size() == 0, {cur_tag, " leftover"},
                exp_w.size() + exp_f.size(), 0);
         end
         if (prev_done) chk(!done_o, "R13 done pulse", done_o, 0);
         prev_done = done_o;
      end
   end

   task automatic launch(bit op, bit nib, logic [15:0] req);
      start_i = 1; op_i = op; nib_i = nib; req_cnt_i = req;
      @(posedge clk); #2;
      start_i = 0;
   endtask

   task automatic put_frame(logic [7:0] d, bit last, bit mk);
      frm_valid_i = 1; frm_data_i = d; frm_last_i = last; frm_mark_i = mk;
      forever begin @(negedge clk); if (frm_ready_o) break; end
      @(posedge clk); #2;
      frm_valid_i = 0; frm_last_i = 0; frm_mark_i = 0;
   endtask

   task automatic put_word(logic [15:0] d);
      wr_valid_i = 1; wr_data_i = d;
      forever begin @(negedge clk); if (wr_ready_o) break; end
      @(posedge clk); #2;
      wr_valid_i = 0;
   endtask

   task automatic wait_done;
      forever begin @(negedge clk); if (done_o) break; end
      @(posedge clk); #2;
   endtask

   task automatic model_read(bit nib, logic [15:0] req, logic [7:0] arr[$], bit mk);
      int lanes, w, n, nw;
      lanes = nib ? 4 : 2;
      w = nib ? 4 : 8;
      n = arr.size();
      nw = 0;
      for (int i = 0; i < n; i += lanes) begin
         logic [15:0] v;
         v = '0;
         for (int l = 0; l < lanes; l++)
            if (i + l < n) v = v | ((nib ? 16'(arr[i+l][3:0]) : 16'(arr[i+l])) << (l * w));
         exp_w.push_back(v);
         nw++;
      end
      exp_mark = mk;
      exp_err  = mk || (int'(req) > nw);
      exp_fcnt = mk ? 0 : (n % 65536);
      cur_op = 0;
   endtask

   task automatic run_read(string tag, bit nib, logic [15:0] req, logic [7:0] rec[$], bit rev, bit mk);
      logic [7:0] arr[$];
      if (rev) begin
         for (int i = rec.size() - 1; i >= 0; i--) arr.push_back(rec[i]);
      end else arr = rec;
      cur_tag = tag;
      model_read(nib, req, arr, mk);
      launch(0, nib, req);
      if (mk) put_frame(8'h00, 1, 1);
      else for (int i = 0; i < arr.size(); i++) put_frame(arr[i], i == arr.size() - 1, 0);
      wait_done();
   endtask

   task automatic run_write(string tag, bit nib, logic [15:0] words[$]);
      int lanes, total;
      lanes = nib ? 4 : 2;
      total = 0;
      for (int j = 0; j < words.size(); j++)
         for (int l = 0; l < lanes; l++) begin
            logic [7:0] d;
            bit last;
            d = nib ? {4'h0, words[j][l*4 +: 4]} : words[j][l*8 +: 8];
            last = (j == words.size() - 1) && (l == lanes - 1);
            exp_f.push_back({last, d});
            total++;
         end
      exp_fcnt = (exp_fcnt + total) % 65536;
      exp_err = 0;
      exp_mark = 0;
      cur_op = 1;
      cur_tag = tag;
      launch(1, nib, 16'(words.size()));
      for (int j = 0; j < words.size(); j++) put_word(words[j]);
      wait_done();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      report();
   end

   initial begin
      logic [7:0] rec[$];
      logic [15:0] wl[$];
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!busy_o && !done_o && fcnt_o == 0 && !fcnt_err_o && !mark_o, "R1 status", fcnt_o, 0);
      chk(!word_valid_o && !tx_valid_o && !frm_ready_o && !wr_ready_o, "R1 streams",
          {word_valid_o, tx_valid_o, frm_ready_o, wr_ready_o}, 0);
      @(posedge clk); #2;
      mon_on = 1;

      // R2 byte read, odd length so R5 padding on last word
      rec = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A};
      run_read("R2", 0, 16'd3, rec, 0, 0);
      // R6 short record: 2 words delivered, 3 requested
      rec = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
      run_read("R6", 0, 16'd3, rec, 0, 0);
      // R3 nibble read, upper bits set and ignored, 6 frames -> R5 pad
      rec = '{8'hF1, 8'hE2, 8'hD3, 8'hC4, 8'hB5, 8'hA6};
      run_read("R3", 1, 16'd2, rec, 0, 0);
      rec = '{8'h01, 8'h02, 8'h03};
      run_read("R5", 1, 16'd1, rec, 0, 0);
      // R4 reverse reads: last frame lands low in first word
      rec = '{8'h11, 8'h22, 8'h33};
      run_read("R4", 0, 16'd2, rec, 1, 0);
      rec = '{8'h1A, 8'h2B, 8'h3C, 8'h4D, 8'h5E};
      run_read("R4", 1, 16'd2, rec, 1, 0);
      // R7 tape mark
      rec = {};
      run_read("R7", 0, 16'd1, rec, 0, 1);

      // R8 byte write, fcnt accumulates from 0
      wl = '{16'hBEEF, 16'h1234, 16'h00FF};
      run_write("R8", 0, wl);
      // R9 nibble write
      wl = '{16'hA5C3, 16'h0F1E};
      run_write("R9", 1, wl);
      // R10 zero-word write leaves fcnt unchanged
      wl = {};
      run_write("R10", 0, wl);

      // R12 backpressure on both sides
      stall_t = 1;
      wl = '{16'h1357, 16'h2468, 16'h9ABC, 16'hDEF0};
      run_write("R12", 0, wl);
      stall_t = 0;
      stall_w = 1;
      rec = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70};
      run_read("R12", 0, 16'd4, rec, 0, 0);
      rec = '{8'h91, 8'h82, 8'h73, 8'h64, 8'h55};
      run_read("R12", 1, 16'd3, rec, 0, 0);
      stall_w = 0;

      // R11 start while busy: try to switch to nibble write mid-record
      cur_tag = "R11";
      rec = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4};
      model_read(0, 16'd3, rec, 0);
      launch(0, 0, 16'd3);
      put_frame(rec[0], 0, 0);
      start_i = 1; op_i = 1; nib_i = 1; req_cnt_i = 16'd7;
      put_frame(rec[1], 0, 0);
      start_i = 0;
      put_frame(rec[2], 0, 0);
      put_frame(rec[3], 0, 0);
      put_frame(rec[4], 1, 0);
      wait_done();
      @(negedge clk);
      chk(!tx_valid_o && !busy_o, "R11 no write started", {tx_valid_o, busy_o}, 0);
      @(posedge clk); #2;

      // R6 frame count of a long record, then R10 wrap of the accumulating count
      rec = {};
      for (int k = 0; k < 65534; k++) rec.push_back(8'(k ^ (k >> 8)));
      run_read("R6", 0, 16'd0, rec, 0, 0);
      wl = '{16'h4242};
      run_write("R10", 0, wl);
      @(negedge clk);
      chk(fcnt_o == 16'h0000, "R10 wrap", fcnt_o, 0);

      repeat (3) @(posedge clk);
      report();
   end
endmodule